// File: doc/BRIEF.md
# Reload-Capture-Compare Down-Counter Timer

This block is a 16-bit timer built around a down-counter. The counter advances on a prescaled tick enable supplied from outside. When a tick finds the counter at zero, it reloads from a reload value and emits a one-clock overflow pulse. A masked comparator watches the count and shapes a PWM level. The PWM level is set active by each zero reload and set inactive by each compare match. Both pins have their own polarity inversion.

Two asynchronous event inputs are each synchronized and edge-detected. A three-bit mode word per input decides what a rising edge on that input does. It can let a stopped counter start. It can copy the live count into a capture register. It can force an immediate reload. Three sticky event flags (reload, capture, compare) are each gated by an enable and merged onto one interrupt line. A run bit freezes the timer for low power. While it is low, the capture register, the flags and the mode settings are all kept. Register values arrive as plain 16-bit inputs.

Top module: `rcc_timer`

## Requirements
- R1: While the timer is active, each clock with `tick` high decrements a nonzero `count` by one. A clock with `tick` low leaves `count` unchanged.
- R2: A tick that finds `count` at zero loads `reload_val` into `count`. The internal overflow level is high for exactly the following clock, and flag bit 0 (reload) is set.
- R3: The internal PWM level goes to 1 after a zero-reload tick and goes to 0 after a compare-match tick. When both fall on the same tick, the level goes to 1. Otherwise it holds.
- R4: A tick with `(count & mask_val) == (cmp_val & mask_val)` is a compare match and sets flag bit 2 (compare).
- R5: `pwm` is the internal PWM level XOR `pwm_inv`. `ovf` is the internal overflow level XOR `ovf_inv`.
- R6: In each `evt_mode_*` word, bit 1 enables capture. On a rising edge of a capture-enabled input, the pre-update `count` is copied into `cap` and flag bit 1 (capture) is set. An input change sampled at clock edge k produces this copy at edge k+2. `cap` changes at no other time.
- R7: In each mode word, bit 0 enables start. If either mode word has bit 0 set, the counter ignores ticks until a rising edge arrives on a start-enabled input. If neither has bit 0 set, the counter runs freely.
- R8: In each mode word, bit 2 enables reload. A rising edge on a reload-enabled input loads `reload_val` into `count`, sets flag bit 0 and gives no overflow pulse. It takes priority over a tick in the same clock.
- R9: While `run` is low, `count` is 0, both internal levels are 0, a pending start is forgotten and input events have no effect. `cap` and the flags keep their values.
- R10: Flags are sticky. A 1 in `irq_clr` clears that flag, but a set in the same clock wins.
- R11: `irq` is high when any flag is set together with its bit in `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Run/freeze control |
| tick | input | 1 | Prescaled count enable |
| reload_val | input | 16 | Reload value |
| cmp_val | input | 16 | Compare value |
| mask_val | input | 16 | Compare mask, 1 = bit compared |
| evt_in | input | 2 | Asynchronous event inputs |
| evt_mode_0 | input | 3 | Mode of evt_in[0]: [0] start, [1] capture, [2] reload |
| evt_mode_1 | input | 3 | Mode of evt_in[1], same encoding |
| pwm_inv | input | 1 | PWM polarity invert |
| ovf_inv | input | 1 | Overflow polarity invert |
| irq_en | input | 3 | Flag enables, [0] reload, [1] capture, [2] compare |
| irq_clr | input | 3 | Flag clear strobes, same bit order |
| count | output | 16 | Current count |
| cap | output | 16 | Captured count |
| pwm | output | 1 | PWM pin |
| ovf | output | 1 | Overflow pin |
| flags | output | 3 | Sticky flags, [0] reload, [1] capture, [2] compare |
| irq | output | 1 | Combined interrupt |

## Verification
Two collisions get the most attention.

The first is a zero reload and a compare match on the same tick. Setting the compare value to zero with a full mask provokes it. The check is that the PWM level ends active while the compare flag is still raised.

The second is a capture and a forced reload from the same edge. One input is given both mode bits and then pulsed. The check is that `cap` holds the count from before the reload and that `count` holds the reload value.

A behavioural model in the bench predicts every output on every clock, so these collisions are judged in the very clock they occur.

// File: rtl/rcc_pkg.sv
// Package rcc_pkg
// Shared encodings for the reload-capture-compare timer: the per-input mode
// word layout and the flag bit order. Assumes three modes and three flags.
package rcc_pkg;
    localparam int MODE_W   = 3;
    localparam int NFLAG    = 3;
    localparam int NEVT     = 2;

    // mode word bit positions
    localparam int MB_START  = 0;
    localparam int MB_CAPT   = 1;
    localparam int MB_RELOAD = 2;

    // flag bit positions
    localparam int FB_RELOAD = 0;
    localparam int FB_CAPT   = 1;
    localparam int FB_CMP    = 2;

    typedef struct packed {
        logic reload;
        logic capt;
        logic start;
    } evt_mode_t;
endpackage

// File: rtl/rcc_sync_edge.sv
// Module rcc_sync_edge
// Brings an asynchronous input into the clock domain through STAGES flops
// and flags a rising edge with one extra flop. Assumes STAGES >= 2.
module rcc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    // shift the input through the synchronizer and the edge flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6
endmodule

// File: rtl/rcc_counter.sv
// Module rcc_counter
// Down-counter with zero reload and forced reload; registers the overflow
// pulse. Assumes step is already gated by run and the start condition.
module rcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic         ext_load,
    input  logic [W-1:0] rl_val,
    output logic [W-1:0] count,
    output logic         zero,
    output logic         zero_evt,
    output logic         ovf_q
);
    assign zero     = (count == '0);
    assign zero_evt = step & zero & ~ext_load;

    // advance, reload or freeze the counter and register the overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= zero_evt;
            if (ext_load)  count <= rl_val;
            else if (step) count <= zero ? rl_val : count - 1'b1;
        end
    end

    AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !zero && !ext_load) |=> count == W'($past(count) - 1'b1)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step && !ext_load) |=> $stable(count)); // R1
    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && zero && !ext_load) |=> (count == $past(rl_val) && ovf_q)); // R2
    AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ext_load) |=> (count == $past(rl_val) && !ovf_q)); // R8
    AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0 && !ovf_q)); // R9
endmodule

// File: rtl/rcc_compare.sv
// Module rcc_compare
// Masked comparator and PWM level: set on zero reload, cleared on match,
// zero reload wins. Assumes step and zero_evt come from the counter stage.
module rcc_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic         zero_evt,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] mask_val,
    output logic         match_evt,
    output logic         pwm_q
);
    logic match;

    assign match     = (((count ^ cmp_val) & mask_val) == '0);
    assign match_evt = step & match;

    // update the PWM level from reload and match events
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pwm_q <= 1'b0;
        else if (zero_evt)  pwm_q <= 1'b1;
        else if (match_evt) pwm_q <= 1'b0;
    end

    AST_ZERO_SETS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (run && zero_evt) |=> pwm_q); // R3
    AST_MATCH_CLEARS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (run && match_evt && !zero_evt) |=> !pwm_q); // R3
    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !zero_evt && !match_evt) |=> $stable(pwm_q)); // R3
endmodule

// File: rtl/rcc_flags.sv
// Module rcc_flags
// Sticky event flags with write-one-to-clear strobes (set wins) and an
// enabled OR onto one interrupt. Assumes set and clr are single-cycle strobes.
module rcc_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    // hold, clear or set each flag
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & en);

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set))); // R10
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((flags & $past(clr & ~set)) == '0)); // R10
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set == '0 && clr == '0) |=> $stable(flags)); // R10
endmodule

// File: rtl/rcc_timer.sv
// Module rcc_timer
// Top of the reload-capture-compare timer: decodes event modes, gates the
// count with run and start state, captures, and applies pin polarity.
// Assumes tick is a one-clock enable from an external prescaler.
module rcc_timer
    import rcc_pkg::*;
#(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [W-1:0]      reload_val,
    input  logic [W-1:0]      cmp_val,
    input  logic [W-1:0]      mask_val,
    input  logic [NEVT-1:0]   evt_in,
    input  logic [MODE_W-1:0] evt_mode_0,
    input  logic [MODE_W-1:0] evt_mode_1,
    input  logic              pwm_inv,
    input  logic              ovf_inv,
    input  logic [NFLAG-1:0]  irq_en,
    input  logic [NFLAG-1:0]  irq_clr,
    output logic [W-1:0]      count,
    output logic [W-1:0]      cap,
    output logic              pwm,
    output logic              ovf,
    output logic [NFLAG-1:0]  flags,
    output logic              irq
);
    evt_mode_t         modes [NEVT];
    logic [NEVT-1:0]   rise, sel_start, sel_capt, sel_rel;
    logic              started, free_run, active, step;
    logic              start_evt, capt_evt, ext_load;
    logic              zero, zero_evt, ovf_q, match_evt, pwm_q;
    logic [NFLAG-1:0]  flag_set;

    assign modes[0] = evt_mode_t'(evt_mode_0);
    assign modes[1] = evt_mode_t'(evt_mode_1);

    for (genvar i = 0; i < NEVT; i++) begin : g_evt
        rcc_sync_edge #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (evt_in[i]),
            .rise (rise[i])
        );
        assign sel_start[i] = modes[i].start;
        assign sel_capt[i]  = modes[i].capt;
        assign sel_rel[i]   = modes[i].reload;
    end

    assign start_evt = |(rise & sel_start);
    assign capt_evt  = run & |(rise & sel_capt);
    assign ext_load  = run & |(rise & sel_rel);
    assign free_run  = ~|sel_start;
    assign active    = run & (free_run | started);
    assign step      = active & tick;

    // remember that a start edge has been seen; forgotten while frozen
    always_ff @(posedge clk) begin
        if (!rst_n || !run) started <= 1'b0;
        else if (start_evt) started <= 1'b1;
    end

    // copy the live count on a capture edge
    always_ff @(posedge clk) begin
        if (!rst_n)        cap <= '0;
        else if (capt_evt) cap <= count;
    end

    rcc_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (step),
        .ext_load(ext_load),
        .rl_val  (reload_val),
        .count   (count),
        .zero    (zero),
        .zero_evt(zero_evt),
        .ovf_q   (ovf_q)
    );

    rcc_compare #(.W(W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .step     (step),
        .zero_evt (zero_evt),
        .count    (count),
        .cmp_val  (cmp_val),
        .mask_val (mask_val),
        .match_evt(match_evt),
        .pwm_q    (pwm_q)
    );

    assign flag_set[FB_RELOAD] = zero_evt | ext_load;
    assign flag_set[FB_CAPT]   = capt_evt;
    assign flag_set[FB_CMP]    = match_evt;

    rcc_flags #(.N(NFLAG)) u_flg (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set),
        .clr  (irq_clr),
        .en   (irq_en),
        .flags(flags),
        .irq  (irq)
    );

    assign pwm = pwm_q ^ pwm_inv;
    assign ovf = ovf_q ^ ovf_inv;

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capt_evt |=> cap == $past(count)); // R6
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capt_evt |=> $stable(cap)); // R9
    AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !free_run && !started && !ext_load) |=> $stable(count)); // R7
    AST_FROZEN_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cap)); // R9
endmodule

// File: tb/tb_rcc_timer.sv
// Bench for rcc_timer: a behavioural reference model predicts every output on
// each clock, and directed checks cover resets, freezes and collisions.
module tb_rcc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, tick = 1'b0;
    logic [15:0] reload_val = '0, cmp_val = '0, mask_val = '0;
    logic [1:0]  evt_in = '0;
    logic [2:0]  evt_mode_0 = '0, evt_mode_1 = '0;
    logic        pwm_inv = 1'b0, ovf_inv = 1'b0;
    logic [2:0]  irq_en = '0, irq_clr = '0;
    logic [15:0] count, cap;
    logic        pwm, ovf, irq;
    logic [2:0]  flags;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rcc_timer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .reload_val(reload_val), .cmp_val(cmp_val), .mask_val(mask_val),
        .evt_in(evt_in), .evt_mode_0(evt_mode_0), .evt_mode_1(evt_mode_1),
        .pwm_inv(pwm_inv), .ovf_inv(ovf_inv), .irq_en(irq_en), .irq_clr(irq_clr),
        .count(count), .cap(cap), .pwm(pwm), .ovf(ovf), .flags(flags), .irq(irq)
    );

    // reference model state
    logic [15:0] m_count, m_cap;
    logic        m_pwm, m_ovf, m_started;
    logic [2:0]  m_flags;
    bit   [2:0]  sy0, sy1; // per input: [0] first flop, [1] second, [2] edge flop

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model update on every rising edge, from the inputs held since the falling edge
    always @(posedge clk) begin
        bit r0, r1, stp, xl, cp, st, zev, mt, act_m, free_m;
        if (!rst_n) begin
            m_count = 0; m_cap = 0; m_pwm = 0; m_ovf = 0; m_started = 0;
            m_flags = 0; sy0 = 0; sy1 = 0;
        end else begin
            r0 = sy0[1] && !sy0[2];
            r1 = sy1[1] && !sy1[2];
            sy0 = {sy0[1], sy0[0], evt_in[0]};
            sy1 = {sy1[1], sy1[0], evt_in[1]};
            free_m = !(evt_mode_0[0] || evt_mode_1[0]);
            st     = (r0 && evt_mode_0[0]) || (r1 && evt_mode_1[0]);
            act_m  = run && (free_m || m_started);
            stp    = act_m && tick;
            xl     = run && ((r0 && evt_mode_0[2]) || (r1 && evt_mode_1[2]));
            cp     = run && ((r0 && evt_mode_0[1]) || (r1 && evt_mode_1[1]));
            zev    = stp && (m_count == 0) && !xl;
            mt     = stp && (((m_count ^ cmp_val) & mask_val) == 0);
            m_flags = (m_flags & ~irq_clr) | {mt, cp, zev || xl};
            if (cp) m_cap = m_count;
            if (!run) begin
                m_count = 0; m_ovf = 0; m_pwm = 0; m_started = 0;
            end else begin
                m_ovf = zev;
                if (xl) m_count = reload_val;
                else if (stp) m_count = (m_count == 0) ? reload_val : m_count - 16'd1;
                if (zev) m_pwm = 1;
                else if (mt) m_pwm = 0;
                if (st) m_started = 1;
            end
        end
    end

    // compare every output a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk("R1 count", count, m_count);
            chk("R5 pwm pin", pwm, m_pwm ^ pwm_inv);
            chk("R2 ovf pin", ovf, m_ovf ^ ovf_inv);
            chk("R6 cap", cap, m_cap);
            chk("R10 flags", flags, m_flags);
            chk("R11 irq", irq, |(m_flags & irq_en));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx, input int hi);
        evt_in[idx] = 1'b1; cyc(hi); evt_in[idx] = 1'b0;
    endtask

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] held;
        cyc(3);
        #5;
        chk("R9 reset count", count, 16'd0);
        chk("R10 reset flags", flags, 3'd0);
        chk("R11 reset irq", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // free run, compare at 2
        reload_val = 16'd5; cmp_val = 16'd2; mask_val = 16'hFFFF;
        irq_en = 3'b111; run = 1'b1; tick = 1'b1;
        cyc(1); #5;
        chk("R2 first zero tick reload", count, 16'd5);
        chk("R2 overflow pulse", ovf, 1'b1);
        chk("R2 reload flag", flags[0], 1'b1);
        @(negedge clk);
        cyc(40);
        chk("R4 compare flag", flags[2], 1'b1);
        chk("R11 irq with flags", irq, 1'b1);

        // sparse ticks
        for (int i = 0; i < 30; i++) begin
            tick = (i % 3 == 0); cyc(1);
        end
        tick = 1'b0; held = count; cyc(5);
        chk("R1 no tick holds", count, held);

        // polarity
        pwm_inv = 1'b1; ovf_inv = 1'b1; tick = 1'b1; cyc(20);
        pwm_inv = 1'b0; ovf_inv = 1'b0;

        // masked compare: odd counts match
        reload_val = 16'd9; cmp_val = 16'h0003; mask_val = 16'h0001; cyc(30);

        // write-one-to-clear
        tick = 1'b0; irq_clr = 3'b111; cyc(1); irq_clr = 3'b000; #5;
        chk("R10 clear all", flags, 3'd0);
        chk("R11 irq low after clear", irq, 1'b0);
        tick = 1'b1; irq_clr = 3'b001; cyc(25); irq_clr = 3'b000;

        // capture on input 1
        reload_val = 16'd1000; mask_val = 16'hFFFF; cmp_val = 16'd500;
        evt_mode_1 = 3'b010; cyc(10);
        pulse(1, 4); cyc(6);
        chk("R6 capture flag", flags[1], 1'b1);

        // forced reload on input 0
        evt_mode_0 = 3'b100; cyc(3); pulse(0, 3); cyc(6);

        // collisions: zero reload with compare at zero, capture with reload
        reload_val = 16'd3; cmp_val = 16'd0; mask_val = 16'hFFFF; cyc(20);
        evt_mode_0 = 3'b110; pulse(0, 2); cyc(8);

        // freeze with events pending
        held = cap; run = 1'b0; cyc(2);
        pulse(0, 3); pulse(1, 3); cyc(5);
        chk("R9 frozen count", count, 16'd0);
        chk("R9 frozen cap", cap, held);
        run = 1'b1; cyc(15);

        // start mode
        evt_mode_0 = 3'b001; evt_mode_1 = 3'b000; run = 1'b0; cyc(2);
        run = 1'b1; cyc(2); held = count; cyc(20);
        chk("R7 waits for start", count, held);
        pulse(0, 2); cyc(20);

        // enables off
        irq_en = 3'b000; cyc(5);
        chk("R11 disabled irq", irq, 1'b0);
        cyc(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule